// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block is the host-side controller for a single-channel, 14-bit converter with a parallel output bus, used in the mode where the host supplies the conversion clock. After reset it waits out the converter's wake-up interval. It then sends a burst of conversion-clock pulses with the convert-start line held high, which the converter needs before its first sample. From that point it runs conversions one at a time.

Each conversion follows a fixed order. The convert-start line goes low to acquire the input and goes high to start the conversion. The conversion clock then runs until the converter signals end-of-conversion, and never before the 17th clock. Chip select and read are pulsed together to take the 14-bit two's-complement word off the bus. The bus then stays idle for a quiet window before the next acquisition may begin. All timing parameters are given in system-clock cycles.

The result leaves the block on a valid/ready stream as a 16-bit sign-extended word. `res_valid_o` stays high and `res_data_o` stays constant until the cycle in which `res_ready_i` is high. While a result is waiting, no new acquisition begins, so back-pressure stalls the converter rather than dropping samples. A one-cycle `start_i` asks for one conversion. While `continuous_i` is high, conversions repeat.

Top module: `adc_seq_ctrl`

## Requirements
- R1: From reset, the outputs are: `adc_convst_o`=1, `adc_cs_n_o`=1, `adc_rd_n_o`=1, `adc_cnv_clk_o`=0, `res_valid_o`=0, `busy_o`=0 and `timeout_err_o`=0. No conversion-clock edge appears during the first WAKE_CYC cycles after reset.
- R2: Before the first acquisition, exactly PWRUP_PULSES (20) full conversion-clock pulses are issued, all with `adc_convst_o` high.
- R3: During every acquisition, `adc_convst_o` stays low for at least ACQ_CYC cycles.
- R4: The first conversion-clock rising edge comes no later than CLK_HALF+1 cycles after `adc_convst_o` rises. The conversion clock has a period of 2*CLK_HALF cycles.
- R5: A read begins only after `adc_eoc_n_i` (active low) is seen low and at least 17 conversion-clock rising edges have occurred since `adc_convst_o` rose. An early end-of-conversion does not shorten this. Exactly 17 rising edges come before the read.
- R6: During a read, `adc_cs_n_o` and `adc_rd_n_o` go low together for RD_CYC cycles, and `adc_convst_o` stays high throughout.
- R7: At least QUIET_CYC cycles separate a rising edge of `adc_rd_n_o` from the next falling edge of `adc_convst_o`.
- R8: The 14-bit code has its sign in bit 13. It is delivered as a 16-bit value with bit 13 copied into bits 15:14. Examples: 0x1FFF gives 0x1FFF, 0x2000 gives 0xE000, 0x3FFF gives 0xFFFF, 0x0000 gives 0x0000.
- R9: Once `res_valid_o` is high, it and `res_data_o` hold until a cycle with `res_ready_i` high. No acquisition starts while a result is pending.
- R10: In the idle state, a `start_i` pulse gives exactly one conversion. While `continuous_i` is high, conversions follow back to back.
- R11: If end-of-conversion has not been seen after TIMEOUT_PULSES conversion-clock pulses, `timeout_err_o` is set, the block returns to acquisition, and the flag stays set until reset.
- R12: `busy_o` is high from the start of acquisition until the read strobe ends, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion (sampled only when idle) |
| continuous_i | input | 1 | Repeat conversions while high |
| adc_eoc_n_i | input | 1 | End-of-conversion from the converter, active low |
| adc_data_i | input | 14 | Converter parallel data bus |
| adc_convst_o | output | 1 | Convert-start line: low acquires, rising edge starts conversion |
| adc_cnv_clk_o | output | 1 | Conversion clock to the converter |
| adc_cs_n_o | output | 1 | Chip select, active low |
| adc_rd_n_o | output | 1 | Read strobe, active low |
| res_data_o | output | 16 | Sign-extended result |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result consumer ready |
| busy_o | output | 1 | Conversion in progress |
| timeout_err_o | output | 1 | Sticky end-of-conversion timeout flag |

## Verification
A sequencer stuck in the wrong state shows up at the converter pins within one conversion. The read starts after the wrong number of clock edges, the convert-start low phase is too short, or the quiet gap before the next acquisition shrinks. Each of these is measured edge by edge against the parameters. A fault in the result path shows up at the first handshake after it, as a value that does not match the scoreboard's independently sign-extended code. A fault in the stall logic shows up during a held back-pressure window, as a changing output or an unexpected acquisition.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_WAKE,
    ST_PUCLK,
    ST_IDLE,
    ST_ACQ,
    ST_CONV,
    ST_READ,
    ST_QUIET
  } seq_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int W = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= W'(RST_VAL);
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_clkgen.sv
module adc_seq_clkgen #(
  parameter int HALF = 8,
  parameter int CW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic          cnv_clk,
  output logic [CW-1:0] rises,
  output logic          fall_due
);
  localparam int HW = (HALF < 2) ? 1 : $clog2(HALF);

  logic [HW-1:0] ph_q;
  logic          ph_end;

  assign ph_end   = (ph_q == HW'(HALF - 1));
  assign fall_due = cnv_clk && ph_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= '0;
      cnv_clk <= 1'b0;
      rises   <= '0;
    end else if (!en) begin
      ph_q    <= '0;
      cnv_clk <= 1'b0;
      rises   <= '0;
    end else if (ph_end) begin
      ph_q    <= '0;
      cnv_clk <= ~cnv_clk;
      if (!cnv_clk && rises != '1) rises <= rises + 1'b1;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
  parameter int IW = 14,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [IW-1:0] code,
  input  logic          ready,
  output logic [OW-1:0] data,
  output logic          valid
);
  localparam int EXT = OW - IW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
    end else if (capture) begin
      data  <= {{EXT{code[IW-1]}}, code};
      valid <= 1'b1;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CODE_W         = 14,
  parameter int RES_W          = 16,
  parameter int WAKE_CYC       = 125000,
  parameter int PWRUP_PULSES   = 20,
  parameter int CLK_HALF       = 8,
  parameter int ACQ_CYC        = 50,
  parameter int LAT_PULSES     = 17,
  parameter int TIMEOUT_PULSES = 32,
  parameter int RD_CYC         = 4,
  parameter int QUIET_CYC      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              continuous_i,
  input  logic              adc_eoc_n_i,
  input  logic [CODE_W-1:0] adc_data_i,
  output logic              adc_convst_o,
  output logic              adc_cnv_clk_o,
  output logic              adc_cs_n_o,
  output logic              adc_rd_n_o,
  output logic [RES_W-1:0]  res_data_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic              busy_o,
  output logic              timeout_err_o
);
  localparam int TW = $clog2(umax(umax(WAKE_CYC, ACQ_CYC), umax(RD_CYC, QUIET_CYC)) + 1);
  localparam int PW = $clog2(umax(umax(PWRUP_PULSES, TIMEOUT_PULSES), LAT_PULSES) + 1);

  seq_state_e    st_q, st_d;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          clk_en, fall_due;
  logic [PW-1:0] rises;
  logic [1:0]    eoc_sync_q;
  logic          eoc_seen;
  logic          timeout_hit;
  logic          capture;

  // end-of-conversion crosses from the converter: two-stage synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eoc_sync_q <= 2'b11;
    else        eoc_sync_q <= {eoc_sync_q[0], adc_eoc_n_i};
  end
  assign eoc_seen = !eoc_sync_q[1];

  assign clk_en = (st_q == ST_PUCLK) || (st_q == ST_CONV);

  adc_seq_clkgen #(.HALF(CLK_HALF), .CW(PW)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .en(clk_en),
    .cnv_clk(adc_cnv_clk_o), .rises(rises), .fall_due(fall_due)
  );

  adc_seq_timer #(.W(TW), .RST_VAL(WAKE_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  assign timeout_hit = (st_q == ST_CONV) && !(eoc_seen && rises >= PW'(LAT_PULSES))
                       && rises == PW'(TIMEOUT_PULSES) && fall_due;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_WAKE:  if (tmr_exp) st_d = ST_PUCLK;
      ST_PUCLK: if (rises == PW'(PWRUP_PULSES) && fall_due) st_d = ST_IDLE;
      ST_IDLE:  if ((start_i || continuous_i) && !res_valid_o) st_d = ST_ACQ;
      ST_ACQ:   if (tmr_exp) st_d = ST_CONV;
      ST_CONV: begin
        if (eoc_seen && rises >= PW'(LAT_PULSES)) st_d = ST_READ;
        else if (timeout_hit)                     st_d = ST_ACQ;
      end
      ST_READ:  if (tmr_exp) st_d = ST_QUIET;
      ST_QUIET: if (tmr_exp) st_d = ST_IDLE;
      default:  st_d = ST_WAKE;
    endcase
  end

  assign tmr_load = (st_d != st_q);
  always_comb begin
    case (st_d)
      ST_ACQ:   tmr_val = TW'(ACQ_CYC - 1);
      ST_READ:  tmr_val = TW'(RD_CYC - 1);
      ST_QUIET: tmr_val = TW'(QUIET_CYC - 1);
      default:  tmr_val = '0;
    endcase
  end

  assign capture = (st_q == ST_READ) && tmr_exp;

  adc_seq_capture #(.IW(CODE_W), .OW(RES_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .capture(capture), .code(adc_data_i),
    .ready(res_ready_i), .data(res_data_o), .valid(res_valid_o)
  );

  // pin drivers registered from the next state so they line up with st_q
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_WAKE;
      adc_convst_o  <= 1'b1;
      adc_rd_n_o    <= 1'b1;
      adc_cs_n_o    <= 1'b1;
      busy_o        <= 1'b0;
      timeout_err_o <= 1'b0;
    end else begin
      st_q         <= st_d;
      adc_convst_o <= (st_d != ST_ACQ);
      adc_rd_n_o   <= (st_d != ST_READ);
      adc_cs_n_o   <= (st_d != ST_READ);
      busy_o       <= (st_d == ST_ACQ) || (st_d == ST_CONV) || (st_d == ST_READ);
      if (timeout_hit) timeout_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adc_convst_o,
  input logic             adc_cs_n_o,
  input logic             adc_rd_n_o,
  input logic [RES_W-1:0] res_data_o,
  input logic             res_valid_o,
  input logic             res_ready_i,
  input logic             busy_o,
  input logic             timeout_err_o
);
  // R6: convert-start stays high and chip select is low while read is low
  a_r6_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n_o |-> (adc_convst_o && !adc_cs_n_o));

  // R7: read release is never followed at once by acquisition
  a_r7_quiet_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_rd_n_o) |=> adc_convst_o);

  // R9: a pending result holds value and valid
  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o)));

  // R11: timeout flag is sticky
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err_o |=> timeout_err_o);

  // R12: acquisition always reports busy
  a_r12_busy_in_acq: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_convst_o |-> busy_o);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_convst_o(adc_convst_o), .adc_cs_n_o(adc_cs_n_o),
  .adc_rd_n_o(adc_rd_n_o), .res_data_o(res_data_o), .res_valid_o(res_valid_o),
  .res_ready_i(res_ready_i), .busy_o(busy_o), .timeout_err_o(timeout_err_o)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int WAKE = 200, PWR = 20, HALF = 4, ACQ = 6, LAT = 17, TMO = 30, RD = 3, QUIET = 5;

  logic clk = 0, rst_n = 0;
  logic start = 0, cont = 0, ready = 1;
  logic eoc_n = 1;
  logic [13:0] adc_bus = '0;
  logic convst, cnv_clk, cs_n, rd_n, valid, busy, err;
  logic [15:0] data;

  always #4 clk = ~clk;

  adc_seq_ctrl #(.WAKE_CYC(WAKE), .PWRUP_PULSES(PWR), .CLK_HALF(HALF), .ACQ_CYC(ACQ),
    .LAT_PULSES(LAT), .TIMEOUT_PULSES(TMO), .RD_CYC(RD), .QUIET_CYC(QUIET)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .continuous_i(cont),
    .adc_eoc_n_i(eoc_n), .adc_data_i(adc_bus), .adc_convst_o(convst),
    .adc_cnv_clk_o(cnv_clk), .adc_cs_n_o(cs_n), .adc_rd_n_o(rd_n),
    .res_data_o(data), .res_valid_o(valid), .res_ready_i(ready),
    .busy_o(busy), .timeout_err_o(err));

  int n_chk = 0, n_err = 0;
  logic [13:0] stub_q[$];
  logic [15:0] exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one code for the stub, its independently sign-extended value for the scoreboard
  task automatic push_code(input logic [13:0] c);
    int v;
    v = (c >= 14'd8192) ? int'(c) - 16384 : int'(c);
    stub_q.push_back(c);
    exp_q.push_back(16'(v));
  endtask

  // behavioural converter stub
  bit stub_armed = 0, mute = 0, early = 0, mute_l = 0, early_l = 0;
  int stub_cnt = 0;
  always @(posedge convst) begin
    stub_armed = 1; stub_cnt = 0; mute_l = mute; early_l = early;
  end
  always @(negedge convst) begin
    stub_armed = 0; eoc_n = 1;
  end
  always @(posedge cnv_clk) if (stub_armed && convst) begin
    stub_cnt++;
    if (!mute_l && stub_cnt == (early_l ? 5 : LAT)) begin
      eoc_n = 0;
      adc_bus = (stub_q.size() != 0) ? stub_q.pop_front() : 14'h0;
    end
  end

  // monitor: pin timing and scoreboard, sampled mid-cycle
  int cyc = 0, pu_rises = 0, conv_rises = 0, t_acq = 0, t_conv = 0, t_rd = -1000, rd_len = 0;
  int conv_falls = 0;
  bit seen_first_fall = 0, seen_first_rise = 0, first_conv_rise = 0, in_conv = 0;
  logic p_convst = 1, p_clk = 0, p_rd = 1;
  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (cnv_clk && !p_clk) begin
      if (!seen_first_rise) begin
        seen_first_rise = 1;
        check(cyc >= WAKE, "R1 wake before first clock", cyc, WAKE);
      end
      if (!seen_first_fall) pu_rises++;
      if (in_conv) begin
        conv_rises++;
        if (!first_conv_rise) begin
          first_conv_rise = 1;
          check(cyc - t_conv <= HALF + 1, "R4 first clock delay", cyc - t_conv, HALF + 1);
        end
      end
    end
    if (!convst && p_convst) begin
      if (!seen_first_fall) check(pu_rises == PWR, "R2 power-up pulses", pu_rises, PWR);
      else check(cyc - t_rd >= QUIET, "R7 quiet window", cyc - t_rd, QUIET);
      check(busy == 1, "R12 busy in acquisition", busy, 1);
      seen_first_fall = 1; conv_falls++; t_acq = cyc; in_conv = 0;
    end
    if (convst && !p_convst) begin
      check(cyc - t_acq >= ACQ, "R3 acquisition width", cyc - t_acq, ACQ);
      in_conv = 1; conv_rises = 0; first_conv_rise = 0; t_conv = cyc;
    end
    if (!rd_n && p_rd) begin
      check(conv_rises == LAT, "R5 clocks before read", conv_rises, LAT);
      check(!cs_n && convst, "R6 strobe pins", {cs_n, convst}, 2'b01);
      rd_len = 0; in_conv = 0;
    end
    if (!rd_n) begin
      rd_len++;
      if (!convst) check(0, "R6 convst during read", convst, 1);
    end
    if (rd_n && !p_rd) begin
      check(rd_len == RD, "R6 read width", rd_len, RD);
      check(busy == 0, "R12 busy after read", busy, 0);
      t_rd = cyc;
    end
    if (valid && ready) begin
      if (exp_q.size() == 0) check(0, "R8 unexpected result", data, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(data == e, "R8 result value", data, e);
      end
    end
    p_convst = convst; p_clk = cnv_clk; p_rd = rd_n;
  end

  task automatic fin();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", wd, 0);
      fin();
    end
  end

  task automatic one_shot(input logic [13:0] c);
    int f0;
    f0 = conv_falls;
    push_code(c);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    check(conv_falls - f0 == 1, "R10 one conversion per start", conv_falls - f0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({convst, cs_n, rd_n, cnv_clk, valid, busy, err} == 7'b1110000,
          "R1 reset state", {convst, cs_n, rd_n, cnv_clk, valid, busy, err}, 7'b1110000);
    rst_n = 1;
    repeat (WAKE + PWR * 2 * HALF + 20) @(negedge clk);
    check(conv_falls == 0 && busy == 0, "R10 idle without request", conv_falls, 0);

    // R8 boundary codes
    one_shot(14'h0000);
    one_shot(14'h1FFF);
    one_shot(14'h2000);
    one_shot(14'h3FFF);
    one_shot(14'h0001);
    one_shot(14'h2001);

    // R5 early end-of-conversion must not shorten latency
    early = 1;
    one_shot(14'h1234);
    early = 0;

    // R9 back-pressure
    begin
      int f0;
      ready = 0;
      push_code(14'h0ABC);
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      while (!valid) @(negedge clk);
      f0 = conv_falls;
      cont = 1;
      repeat (60) @(negedge clk);
      check(valid == 1, "R9 valid held", valid, 1);
      check(data == 16'h0ABC, "R9 data held", data, 16'h0ABC);
      check(conv_falls == f0, "R9 no acquisition while pending", conv_falls - f0, 0);
      cont = 0;
      @(negedge clk) ready = 1;
      while (exp_q.size() != 0) @(negedge clk);
      repeat (20) @(negedge clk);
    end

    // R10 continuous mode
    begin
      int f0;
      f0 = conv_falls;
      for (int i = 0; i < 5; i++) push_code(14'(16'h0100 * i + 16'h2A5));
      cont = 1;
      while (conv_falls < f0 + 5) @(negedge clk);
      cont = 0;
      while (exp_q.size() != 0) @(negedge clk);
      repeat (40) @(negedge clk);
      check(conv_falls - f0 == 5, "R10 continuous count", conv_falls - f0, 5);
    end

    // R11 timeout then retry
    check(err == 0, "R11 no error before timeout", err, 0);
    mute = 1;
    push_code(14'h3000);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    while (!convst) @(negedge clk);
    mute = 0;
    while (exp_q.size() != 0) @(negedge clk);
    check(err == 1, "R11 timeout flag set", err, 1);
    repeat (50) @(negedge clk);
    check(err == 1, "R11 timeout flag sticky", err, 1);
    check(busy == 0 && valid == 0, "R12 idle at end", {busy, valid}, 0);
    fin();
  end
endmodule